// File: doc/BRIEF.md
# Interrupt Aggregation and Relocation Router

This block collects a large number of level-sensitive peripheral interrupt sources and presents them to an interrupt priority controller as a fixed set of request lines. Sources are grouped in fixed-size blocks. Each request line is the OR of the sources in its block, so one line may be raised by several sources at once. For every line, software can read a monitor word that shows the raw level of each source in the block. From that word it can tell which source is asserting.

Eight relocation slots let software take one chosen source out of its shared group and deliver it alone on a dedicated request line. That line can then have its own handler, and the handler does not have to search for the source. The dedicated lines form a contiguous run starting at a parameterized base (lines 3 to 10 by default). A separate path ORs the external non-maskable request with the hardware-watchdog request onto a single NMI line. The external request is gated by an enable bit that is clear after reset. A two-bit monitor shows which of the two NMI requests is active.

Configuration uses a simple synchronous register write port and a combinational read port. All request outputs are combinational from the source inputs and the registered settings.

Top module: `irq_route_top`

## Requirements
- R1: Request line `l` is the OR of sources `l*G` to `l*G+G-1` (G = SRCS_PER_LINE), minus any relocated source. With all sources low and no watchdog request, every output is low.
- R2: A read at address `l` (l < NUM_LINES) returns the raw level of source `l*G+g` in bit `g`. This holds whether or not that source is relocated.
- R3: Monitor bits at and above G read as zero. An address not named in R2, R4, R8 or R9 reads as zero.
- R4: Slot `k` has its register at address NUM_LINES+k, with the enable in bit 15 and the source index in the low $clog2(NUM_SRC) bits. The register reads back as written, with unused bits zero. An enabled slot drives source `idx` onto line RELOC_BASE+k.
- R5: A source named by an enabled slot no longer contributes to its own group's line.
- R6: A disabled slot adds nothing to its line. That line is then the plain OR of its own group, and a source that the slot used to select returns to its group.
- R7: If two enabled slots name the same source, both of their lines follow that source, and the source stays out of its group.
- R8: `nmi_req_o` = wdg_i OR (ext_nmi_i AND nmi enable). A read at NUM_LINES+NUM_SLOTS returns the gated external request in bit 0 and wdg_i in bit 1.
- R9: The NMI enable is bit 0 of address NUM_LINES+NUM_SLOTS+1. Reset clears it and all slot enables.
- R10: A register write takes effect at the rising edge on which `reg_we_i` is sampled high. Outputs keep their old settings until that edge. Registers that are not addressed keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_LINES*SRCS_PER_LINE | Peripheral interrupt levels |
| ext_nmi_i | input | 1 | External non-maskable request |
| wdg_i | input | 1 | Hardware watchdog request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data |
| irq_req_o | output | NUM_LINES | Request lines to the priority controller |
| nmi_req_o | output | 1 | Merged non-maskable request |

## Verification
Two functions can act in the same cycle: a slot write that relocates a source or releases it, and the source levels that feed both the shared groups and the dedicated lines. The bench changes the sources in the same cycle as the slot write. It checks the lines just before the capturing edge against the old settings, and in the next cycle against the new ones. The scoreboard's expected vectors come from the bench's own copy of the slot table, which is updated only at that edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DATA_W = 16;
  localparam int EN_BIT = 15;

  typedef struct packed {
    logic        en;
    logic [14:0] idx;
  } slot_cfg_t;

  // keep only the index bits that address a real source
  function automatic slot_cfg_t decode_slot(input logic [DATA_W-1:0] w, input int src_w);
    slot_cfg_t c;
    c.en  = w[EN_BIT];
    c.idx = w[14:0] & ((15'(1) << src_w) - 15'(1));
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] encode_slot(input slot_cfg_t c);
    return {c.en, c.idx};
  endfunction

  function automatic logic nmi_merge(input logic ext, input logic en, input logic wdg);
    return (ext & en) | wdg;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int NUM_SLOTS = 8,
  parameter int SRC_W     = 9,
  parameter int AW        = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output slot_cfg_t [NUM_SLOTS-1:0]     cfg_o,
  output logic                          nmi_en_o
);
  localparam int NMI_CTL_ADDR = NUM_LINES + NUM_SLOTS + 1;

  logic [NUM_SLOTS-1:0] wr_hit;
  logic                 nmi_hit;
  slot_cfg_t [NUM_SLOTS-1:0] cfg_q;
  logic                 nmi_en_q;

  assign nmi_hit = we_i && (addr_i == AW'(NMI_CTL_ADDR));

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign wr_hit[k] = we_i && (addr_i == AW'(NUM_LINES + k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cfg_q[k] <= '0;
      else if (wr_hit[k]) cfg_q[k] <= decode_slot(wdata_i, SRC_W);
    end

    AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit[k] |=> (cfg_o[k].en == $past(wdata_i[EN_BIT]))); // R10
    AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_hit[k] |=> $stable(cfg_o[k])); // R10
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      nmi_en_q <= 1'b0;
    else if (nmi_hit) nmi_en_q <= wdata_i[0];
  end

  AST_NMI_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nmi_hit |=> $stable(nmi_en_o)); // R9

  assign cfg_o    = cfg_q;
  assign nmi_en_o = nmi_en_q;
endmodule

// File: rtl/irq_reloc_slots.sv
module irq_reloc_slots
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC   = 512,
  parameter int NUM_SLOTS = 8,
  parameter int SRC_W     = 9
) (
  input  logic [NUM_SRC-1:0]        src_i,
  input  slot_cfg_t [NUM_SLOTS-1:0] cfg_i,
  output logic [NUM_SLOTS-1:0]      slot_drive_o,
  output logic [NUM_SRC-1:0]        reloc_mask_o
);
  logic [NUM_SLOTS-1:0] slot_live;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_drive
    assign slot_live[k]    = cfg_i[k].en && (int'(cfg_i[k].idx) < NUM_SRC);
    assign slot_drive_o[k] = slot_live[k] && src_i[cfg_i[k].idx[SRC_W-1:0]];
  end

  // several slots may name one source: the mask is the union
  always_comb begin
    reloc_mask_o = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (slot_live[k]) reloc_mask_o[cfg_i[k].idx[SRC_W-1:0]] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_group_or.sv
module irq_group_or #(
  parameter int NUM_LINES     = 128,
  parameter int SRCS_PER_LINE = 4,
  localparam int NUM_SRC      = NUM_LINES * SRCS_PER_LINE
) (
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic [NUM_SRC-1:0]   reloc_mask_i,
  output logic [NUM_LINES-1:0] grp_req_o
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign grp_req_o[l] = |(src_i[l*SRCS_PER_LINE +: SRCS_PER_LINE]
                            & ~reloc_mask_i[l*SRCS_PER_LINE +: SRCS_PER_LINE]);
  end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES     = 128,
  parameter int SRCS_PER_LINE = 4,
  parameter int NUM_SLOTS     = 8,
  parameter int RELOC_BASE    = 3,
  parameter int AW            = $clog2(NUM_LINES + NUM_SLOTS + 2)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_LINES*SRCS_PER_LINE-1:0] src_i,
  input  logic                               ext_nmi_i,
  input  logic                               wdg_i,
  input  logic                               reg_we_i,
  input  logic [AW-1:0]                      reg_addr_i,
  input  logic [DATA_W-1:0]                  reg_wdata_i,
  output logic [DATA_W-1:0]                  reg_rdata_o,
  output logic [NUM_LINES-1:0]               irq_req_o,
  output logic                               nmi_req_o
);
  localparam int NUM_SRC      = NUM_LINES * SRCS_PER_LINE;
  localparam int SRC_W        = $clog2(NUM_SRC);
  localparam int NMI_MON_ADDR = NUM_LINES + NUM_SLOTS;
  localparam int NMI_CTL_ADDR = NUM_LINES + NUM_SLOTS + 1;

  slot_cfg_t [NUM_SLOTS-1:0] cfg;
  logic                      nmi_en;
  logic [NUM_SLOTS-1:0]      slot_drive;
  logic [NUM_SRC-1:0]        reloc_mask;
  logic [NUM_LINES-1:0]      grp_req;
  logic                      ext_nmi_gated;

  irq_cfg_regs #(
    .NUM_LINES(NUM_LINES), .NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W), .AW(AW)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .cfg_o(cfg), .nmi_en_o(nmi_en)
  );

  irq_reloc_slots #(
    .NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W)
  ) u_slots (
    .src_i(src_i), .cfg_i(cfg), .slot_drive_o(slot_drive), .reloc_mask_o(reloc_mask)
  );

  irq_group_or #(
    .NUM_LINES(NUM_LINES), .SRCS_PER_LINE(SRCS_PER_LINE)
  ) u_group (
    .src_i(src_i), .reloc_mask_i(reloc_mask), .grp_req_o(grp_req)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_out
    if (l >= RELOC_BASE && l < RELOC_BASE + NUM_SLOTS) begin : g_reloc
      assign irq_req_o[l] = grp_req[l] | slot_drive[l-RELOC_BASE];
    end else begin : g_plain
      assign irq_req_o[l] = grp_req[l];
    end
  end

  assign ext_nmi_gated = ext_nmi_i & nmi_en;
  assign nmi_req_o     = nmi_merge(ext_nmi_i, nmi_en, wdg_i);

  always_comb begin
    int a;
    a = int'(reg_addr_i);
    reg_rdata_o = '0;
    if (a < NUM_LINES) begin
      reg_rdata_o[SRCS_PER_LINE-1:0] = src_i[a*SRCS_PER_LINE +: SRCS_PER_LINE];
    end else if (a < NMI_MON_ADDR) begin
      reg_rdata_o = encode_slot(cfg[a-NUM_LINES]);
    end else if (a == NMI_MON_ADDR) begin
      reg_rdata_o[1:0] = {wdg_i, ext_nmi_gated};
    end else if (a == NMI_CTL_ADDR) begin
      reg_rdata_o[0] = nmi_en;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (irq_req_o == '0)); // R1
  AST_WDG_TO_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_i |-> nmi_req_o); // R8
  AST_NMI_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_en && !wdg_i) |-> !nmi_req_o); // R9

  if (SRCS_PER_LINE < DATA_W) begin : g_rsv
    AST_MON_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(reg_addr_i) < NUM_LINES) |-> (reg_rdata_o[DATA_W-1:SRCS_PER_LINE] == '0)); // R3
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_idle_chk
    AST_SLOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg[k].en && src_i[(RELOC_BASE+k)*SRCS_PER_LINE +: SRCS_PER_LINE] == '0)
        |-> !irq_req_o[RELOC_BASE+k]); // R6
  end
endmodule

// File: tb/irq_route_top_tb_top.sv
`timescale 1ns/1ps
module irq_route_top_tb_top;
  localparam int L = 16, G = 4, S = 8, BASE = 3;
  localparam int NS = L * G;
  localparam int AW = $clog2(L + S + 2);
  localparam int NMI_MON = L + S, NMI_CTL = L + S + 1;

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] src = '0;
  logic ext_nmi = 0, wdg = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [L-1:0] irq;
  logic nmi;
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  irq_route_top #(.NUM_LINES(L), .SRCS_PER_LINE(G), .NUM_SLOTS(S), .RELOC_BASE(BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .ext_nmi_i(ext_nmi), .wdg_i(wdg),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_req_o(irq), .nmi_req_o(nmi));

  // bench copy of the settings, updated only at the capturing edge
  logic       m_en [S];
  int         m_idx[S];
  logic       m_nmi_en;

  typedef struct { logic [L-1:0] irq; logic nmi; string tag; } exp_t;
  exp_t sb[$];
  event smp;

  function automatic logic [L-1:0] model_irq(input logic [NS-1:0] s);
    logic [NS-1:0] hide = '0;
    logic [L-1:0] r;
    for (int k = 0; k < S; k++) if (m_en[k]) hide[m_idx[k]] = 1'b1;
    for (int l = 0; l < L; l++) begin
      r[l] = 1'b0;
      for (int g = 0; g < G; g++) r[l] = r[l] | (s[l*G+g] & !hide[l*G+g]);
    end
    for (int k = 0; k < S; k++) if (m_en[k]) r[BASE+k] = r[BASE+k] | s[m_idx[k]];
    return r;
  endfunction

  function automatic logic model_nmi();
    return wdg | (ext_nmi & m_nmi_en);
  endfunction

  // driver: change the inputs, queue what the outputs must be
  task automatic apply(input logic [NS-1:0] s, input logic e, input logic w, input string tag);
    exp_t x;
    @(negedge clk);
    src = s; ext_nmi = e; wdg = w;
    x.irq = model_irq(s); x.nmi = model_nmi(); x.tag = tag;
    sb.push_back(x);
    #1 ->smp;
  endtask

  // monitor: compare the outputs with the oldest queued item
  initial forever begin
    exp_t x;
    @smp;
    x = sb.pop_front();
    vectors++;
    if (irq !== x.irq || nmi !== x.nmi) begin
      fails++;
      $display("FAIL %s: irq=%h nmi=%b expected irq=%h nmi=%b", x.tag, irq, nmi, x.irq, x.nmi);
    end
  end

  task automatic rd_chk(input int a, input logic [15:0] e, input string tag);
    @(negedge clk);
    addr = AW'(a);
    #1;
    vectors++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s: rdata=%h expected %h", tag, rdata, e);
    end
  endtask

  // write: in the write cycle, the old settings must still hold (R10)
  task automatic wr(input int a, input logic [15:0] d, input logic [NS-1:0] s_during, input string tag);
    exp_t x;
    @(negedge clk);
    we = 1; addr = AW'(a); wdata = d; src = s_during;
    x.irq = model_irq(s_during); x.nmi = model_nmi(); x.tag = {tag, " R10 before edge"};
    sb.push_back(x);
    #1 ->smp;
    @(posedge clk);
    if (a >= L && a < L + S) begin
      m_en[a-L] = d[15];
      m_idx[a-L] = int'(d[5:0]);
    end else if (a == NMI_CTL) m_nmi_en = d[0];
    @(negedge clk);
    we = 0;
  endtask

  function automatic logic [NS-1:0] one(input int i);
    return NS'(1) << i;
  endfunction

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < S; k++) begin m_en[k] = 0; m_idx[k] = 0; end
    m_nmi_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state (R9)
    rd_chk(L + 0, 16'h0000, "R9 slot0 cleared");
    rd_chk(L + 7, 16'h0000, "R9 slot7 cleared");
    rd_chk(NMI_CTL, 16'h0000, "R9 nmi enable cleared");
    apply('0, 0, 0, "R1 idle");

    // plain OR per group (R1)
    apply(one(0), 0, 0, "R1 single src0");
    apply(one(13) | one(14), 0, 0, "R1 two sources same group");
    apply(one(63) | one(5) | one(40), 0, 0, "R1 spread sources");

    // monitors (R2, R3)
    apply(one(41) | one(43), 0, 0, "R2 setup");
    rd_chk(10, 16'h000A, "R2 monitor line10");
    rd_chk(11, 16'h0000, "R2 monitor line11 empty");
    apply('1, 0, 0, "R1 all high");
    rd_chk(3, 16'h000F, "R3 upper monitor bits zero");
    rd_chk(NMI_CTL + 1, 16'h0000, "R3 unmapped address");

    // relocate src40 (group 10) through slot0 onto line3; src changes in write cycle (R4, R5, R10)
    wr(L + 0, 16'h8000 | 16'd40, one(40), "R4 slot0 write");
    apply(one(40), 0, 0, "R5 src40 on line3 only");
    rd_chk(L + 0, 16'h8028, "R4 slot0 readback");
    rd_chk(L + 1, 16'h0000, "R10 slot1 untouched");
    apply(one(40) | one(41), 0, 0, "R5 group10 still ORs others");
    rd_chk(10, 16'h0003, "R2 monitor shows relocated source");
    apply(one(12), 0, 0, "R4 line3 own group kept");
    wr(L + 0, 16'h9FE8, one(40), "R4 upper index bits");
    rd_chk(L + 0, 16'h8028, "R4 unused index bits dropped");

    // two slots on one source (R7)
    wr(L + 1, 16'h8005, '0, "R7 slot1");
    wr(L + 2, 16'h8005, '0, "R7 slot2");
    apply(one(5), 0, 0, "R7 both lines follow src5");
    apply(one(5) | one(4), 0, 0, "R7 group1 from src4 only");

    // disable slots (R6)
    wr(L + 0, 16'h0028, one(40), "R6 slot0 off");
    apply(one(40), 0, 0, "R6 src40 back on line10");
    wr(L + 1, 16'h0005, one(5), "R6 slot1 off");
    apply(one(5), 0, 0, "R6 src5 still hidden by slot2");
    wr(L + 2, 16'h0000, one(5), "R6 slot2 off");
    apply(one(5), 0, 0, "R6 src5 on line1");

    // NMI path (R8, R9)
    apply('0, 1, 0, "R9 external nmi masked");
    rd_chk(NMI_MON, 16'h0000, "R8 monitor masked");
    apply('0, 0, 1, "R8 watchdog alone");
    rd_chk(NMI_MON, 16'h0002, "R8 monitor watchdog");
    wr(NMI_CTL, 16'h0001, '0, "R9 nmi enable");
    rd_chk(NMI_CTL, 16'h0001, "R9 nmi enable readback");
    apply('0, 1, 0, "R8 external nmi passes");
    rd_chk(NMI_MON, 16'h0001, "R8 monitor external");
    apply('0, 1, 1, "R8 both nmi sources");
    rd_chk(NMI_MON, 16'h0003, "R8 monitor both");

    // reset clears settings again (R9)
    wr(L + 3, 16'h8000, '0, "R9 slot3 set");
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < S; k++) m_en[k] = 0;
    m_nmi_en = 0;
    rd_chk(L + 3, 16'h0000, "R9 slot3 cleared by reset");
    apply(one(0), 1, 0, "R9 after reset src0 home, nmi masked");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule